// File: doc/BRIEF.md
# Keyboard Controller Output-Buffer Flags, Interrupts and Address-Line-20 Gate

This block holds the host-facing flag and interrupt logic of a legacy PC keyboard controller. Embedded firmware talks to it over a byte-wide memory-mapped register bus with a write strobe and a combinational read port. A host side issues two kinds of strobe: a read of the output data byte, and an address-line-20 gate command.

A configuration byte decides three things:
- whether the keyboard output-full flag comes from hardware events or from a firmware latch;
- whether the auxiliary output-full flag is set by hardware or is a plain firmware bit;
- whether the address-line-20 gate may be moved by the host at all.

A separate enable bit gates both output-full flags onto registered interrupt outputs, one for the keyboard and one for the mouse.

Firmware addresses used, all 16 bits wide:

| Address | Function |
|---|---|
| 0x7FF1 | output data |
| 0x7FF2 | status |
| 0x7FF4 | configuration |
| 0x7FFA | auxiliary data |
| 0x7FFD | keyboard flag latch |
| 0x7FFE | gate low |
| 0x7FFF | gate high |

Configuration bits:

| Bit | Function |
|---|---|
| 7 | aux-hardware |
| 5 | interrupt enable |
| 3 | stored-only map bit |
| 2 | keyboard-flag-from-latch |
| 1 | firmware-only gate |
| 0 | stored-only sleep bit |

Top module: `kbc_obf_irq`

## Requirements
- R1: After reset the configuration byte reads 0x00, and `pc_obf`, `aux_obf`, `kirq`, `mirq`, `gate_a20` and `host_odata` are all 0.
- R2: A firmware write to 0x7FF4 stores the byte. A read of 0x7FF4 returns it with bits 6 and 4 forced to 0. Bits 3 and 0 read back as written and affect no output.
- R3: With configuration bit 2 clear, `pc_obf` is set by a firmware write to 0x7FF1 and cleared by a host data read (`host_rd_data`).
- R4: With configuration bit 2 set, `pc_obf` equals bit 0 of the last firmware write to 0x7FFD, and host data reads do not change it.
- R5: With configuration bit 7 set, a firmware write to 0x7FFA sets `aux_obf`, and a host data read clears it.
- R6: With configuration bit 7 clear, `aux_obf` takes bit 5 of a firmware write to the status address 0x7FF2. Writes to 0x7FFA and host data reads leave it unchanged.
- R7: A firmware read of 0x7FF2 returns `pc_obf` in bit 0 and `aux_obf` in bit 5, with all other bits 0.
- R8: `kirq` equals configuration bit 5 AND `pc_obf`, and `mirq` equals bit 5 AND `aux_obf`. Each is registered, so it follows its inputs one clock later. With bit 5 clear, both outputs are 0.
- R9: With configuration bit 1 clear, `gate_a20` follows whichever event came last:
  - a host command (`host_a20_cmd` carrying `host_a20_val`);
  - a firmware write to 0x7FFE, which drives the gate to 0;
  - a firmware write to 0x7FFF, which drives the gate to 1.

  The data byte of a 0x7FFE or 0x7FFF write is ignored. If firmware and host act in the same cycle, firmware wins.
- R10: With configuration bit 1 set, host gate commands leave `gate_a20` unchanged, and only firmware writes to 0x7FFE or 0x7FFF move it.
- R11: `host_odata` holds the last byte firmware wrote to 0x7FF1 or 0x7FFA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fw_we | input | 1 | Firmware write strobe |
| fw_addr | input | 16 | Firmware register address |
| fw_wdata | input | 8 | Firmware write data |
| fw_rdata | output | 8 | Firmware read data for `fw_addr` (combinational) |
| host_rd_data | input | 1 | Host reads the output data byte |
| host_a20_cmd | input | 1 | Host address-line-20 command strobe |
| host_a20_val | input | 1 | Gate level requested by the host command |
| host_odata | output | 8 | Output data byte presented to the host |
| pc_obf | output | 1 | Keyboard output-buffer-full flag |
| aux_obf | output | 1 | Auxiliary output-buffer-full flag |
| kirq | output | 1 | Keyboard interrupt |
| mirq | output | 1 | Mouse interrupt |
| gate_a20 | output | 1 | Address-line-20 gate |

## Verification
All four pairings of the aux-hardware and flag-from-latch bits are driven with the same sequence of data writes, latch writes, status writes and host reads. This separates flags that are set by hardware events from flags that are copied from firmware. The interrupt enable is toggled only while the keyboard flag is 0, and the outputs are sampled in both the first and the second cycle after a flag change. Those two samples show both the gating and the one-clock lag. For the gate, host commands and firmware writes are interleaved with the firmware-only bit set and clear, including one cycle where both arrive together, to expose the last-event ordering and the firmware priority.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int FW_AW = 16;
  localparam int FW_DW = 8;

  localparam logic [FW_AW-1:0] A_ODATA = 16'h7FF1;
  localparam logic [FW_AW-1:0] A_STAT  = 16'h7FF2;
  localparam logic [FW_AW-1:0] A_CFG   = 16'h7FF4;
  localparam logic [FW_AW-1:0] A_AUXD  = 16'h7FFA;
  localparam logic [FW_AW-1:0] A_LATCH = 16'h7FFD;
  localparam logic [FW_AW-1:0] A_A20LO = 16'h7FFE;
  localparam logic [FW_AW-1:0] A_A20HI = 16'h7FFF;

  localparam int B_AUXH  = 7;
  localparam int B_IRQEN = 5;
  localparam int B_LATCH = 2;
  localparam int B_FWA20 = 1;

  localparam int S_PCOBF  = 0;
  localparam int S_AUXOBF = 5;

  localparam logic [FW_DW-1:0] CFG_WMASK = 8'hAF;

  typedef enum logic [2:0] {
    T_NONE, T_CFG, T_STAT, T_ODATA, T_AUXD, T_LATCH, T_A20LO, T_A20HI
  } fw_tgt_e;

  function automatic fw_tgt_e decode(input logic [FW_AW-1:0] a);
    case (a)
      A_CFG:   return T_CFG;
      A_STAT:  return T_STAT;
      A_ODATA: return T_ODATA;
      A_AUXD:  return T_AUXD;
      A_LATCH: return T_LATCH;
      A_A20LO: return T_A20LO;
      A_A20HI: return T_A20HI;
      default: return T_NONE;
    endcase
  endfunction

  function automatic logic [FW_DW-1:0] cfg_keep(input logic [FW_DW-1:0] d);
    return d & CFG_WMASK;
  endfunction

  function automatic logic [FW_DW-1:0] stat_byte(input logic pc, input logic aux);
    logic [FW_DW-1:0] s;
    s = '0;
    s[S_PCOBF]  = pc;
    s[S_AUXOBF] = aux;
    return s;
  endfunction

  function automatic logic irq_of(input logic en, input logic flag);
    return en & flag;
  endfunction
endpackage

// File: rtl/kbc_cfg_reg.sv
module kbc_cfg_reg
  import kbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [FW_DW-1:0] wdata,
  output logic [FW_DW-1:0] cfg_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= cfg_keep(wdata);
  end
endmodule

// File: rtl/kbc_obf_flags.sv
module kbc_obf_flags
  import kbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             from_latch,
  input  logic             aux_hw,
  input  logic             odata_wr,
  input  logic             auxd_wr,
  input  logic             stat_wr,
  input  logic             latch_wr,
  input  logic [FW_DW-1:0] wdata,
  input  logic             host_rd,
  output logic             pc_obf,
  output logic             aux_obf,
  output logic [FW_DW-1:0] odata_q
);
  logic pc_hw_q, pc_latch_q, aux_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        pc_hw_q <= 1'b0;
    else if (odata_wr) pc_hw_q <= 1'b1;
    else if (host_rd)  pc_hw_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        pc_latch_q <= 1'b0;
    else if (latch_wr) pc_latch_q <= wdata[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) aux_q <= 1'b0;
    else if (aux_hw) begin
      if (auxd_wr)      aux_q <= 1'b1;
      else if (host_rd) aux_q <= 1'b0;
    end else if (stat_wr) begin
      aux_q <= wdata[S_AUXOBF];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    odata_q <= '0;
    else if (odata_wr || auxd_wr)  odata_q <= wdata;
  end

  assign pc_obf  = from_latch ? pc_latch_q : pc_hw_q;
  assign aux_obf = aux_q;
endmodule

// File: rtl/kbc_irq_gate.sv
module kbc_irq_gate
  import kbc_pkg::*;
#(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] flag,
  output logic [N-1:0] irq
);
  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) irq[i] <= 1'b0;
      else        irq[i] <= irq_of(en, flag[i]);
    end
  end
endmodule

// File: rtl/kbc_a20_arb.sv
module kbc_a20_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic fw_only,
  input  logic fw_lo,
  input  logic fw_hi,
  input  logic host_cmd,
  input  logic host_val,
  output logic gate
);
  always_ff @(posedge clk) begin
    if (!rst_n)                     gate <= 1'b0;
    else if (fw_hi)                 gate <= 1'b1;
    else if (fw_lo)                 gate <= 1'b0;
    else if (host_cmd && !fw_only)  gate <= host_val;
  end
endmodule

// File: rtl/kbc_obf_irq.sv
module kbc_obf_irq
  import kbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fw_we,
  input  logic [FW_AW-1:0] fw_addr,
  input  logic [FW_DW-1:0] fw_wdata,
  output logic [FW_DW-1:0] fw_rdata,
  input  logic             host_rd_data,
  input  logic             host_a20_cmd,
  input  logic             host_a20_val,
  output logic [FW_DW-1:0] host_odata,
  output logic             pc_obf,
  output logic             aux_obf,
  output logic             kirq,
  output logic             mirq,
  output logic             gate_a20
);
  localparam int N_IRQ = 2;

  fw_tgt_e          wr_tgt;
  logic [FW_DW-1:0] cfg_q;
  logic             cfg_wr, stat_wr, odata_wr, auxd_wr, latch_wr;
  logic             a20_fw_lo, a20_fw_hi;
  logic [N_IRQ-1:0] irq_v;

  assign wr_tgt    = fw_we ? decode(fw_addr) : T_NONE;
  assign cfg_wr    = (wr_tgt == T_CFG);
  assign stat_wr   = (wr_tgt == T_STAT);
  assign odata_wr  = (wr_tgt == T_ODATA);
  assign auxd_wr   = (wr_tgt == T_AUXD);
  assign latch_wr  = (wr_tgt == T_LATCH);
  assign a20_fw_lo = (wr_tgt == T_A20LO);
  assign a20_fw_hi = (wr_tgt == T_A20HI);

  kbc_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wdata(fw_wdata), .cfg_q(cfg_q)
  );

  kbc_obf_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .from_latch(cfg_q[B_LATCH]), .aux_hw(cfg_q[B_AUXH]),
    .odata_wr(odata_wr), .auxd_wr(auxd_wr), .stat_wr(stat_wr), .latch_wr(latch_wr),
    .wdata(fw_wdata), .host_rd(host_rd_data),
    .pc_obf(pc_obf), .aux_obf(aux_obf), .odata_q(host_odata)
  );

  kbc_irq_gate #(.N(N_IRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .en(cfg_q[B_IRQEN]),
    .flag({aux_obf, pc_obf}), .irq(irq_v)
  );
  assign kirq = irq_v[0];
  assign mirq = irq_v[1];

  kbc_a20_arb u_a20 (
    .clk(clk), .rst_n(rst_n), .fw_only(cfg_q[B_FWA20]),
    .fw_lo(a20_fw_lo), .fw_hi(a20_fw_hi),
    .host_cmd(host_a20_cmd), .host_val(host_a20_val), .gate(gate_a20)
  );

  always_comb begin
    case (decode(fw_addr))
      T_CFG:   fw_rdata = cfg_q;
      T_STAT:  fw_rdata = stat_byte(pc_obf, aux_obf);
      T_ODATA: fw_rdata = host_odata;
      default: fw_rdata = '0;
    endcase
  end
endmodule

// File: rtl/kbc_obf_irq_chk.sv
module kbc_obf_irq_chk
  import kbc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [FW_DW-1:0] cfg_q,
  input logic             cfg_wr,
  input logic             odata_wr,
  input logic [FW_DW-1:0] fw_wdata,
  input logic             pc_obf,
  input logic             aux_obf,
  input logic             kirq,
  input logic             mirq,
  input logic             gate_a20,
  input logic             host_a20_cmd,
  input logic             host_a20_val,
  input logic             a20_fw_lo,
  input logic             a20_fw_hi
);
  // R8
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[B_IRQEN] |=> (!kirq && !mirq));
  // R8
  kirq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[B_IRQEN] && pc_obf) |=> kirq);
  // R8
  mirq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[B_IRQEN] && aux_obf) |=> mirq);
  // R8: firmware must not flip the interrupt enable while the keyboard flag is set
  irqen_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && pc_obf) |-> (fw_wdata[B_IRQEN] == cfg_q[B_IRQEN]));
  // R3
  pc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (odata_wr && !cfg_q[B_LATCH]) |=> pc_obf);
  // R9
  a20_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a20_fw_hi |=> gate_a20);
  // R9
  a20_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a20_fw_lo && !a20_fw_hi) |=> !gate_a20);
  // R9
  a20_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[B_FWA20] && host_a20_cmd && !a20_fw_lo && !a20_fw_hi)
      |=> (gate_a20 == $past(host_a20_val)));
  // R10
  a20_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[B_FWA20] && !a20_fw_lo && !a20_fw_hi) |=> $stable(gate_a20));
endmodule

bind kbc_obf_irq kbc_obf_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_q(cfg_q), .cfg_wr(cfg_wr), .odata_wr(odata_wr),
  .fw_wdata(fw_wdata), .pc_obf(pc_obf), .aux_obf(aux_obf), .kirq(kirq), .mirq(mirq),
  .gate_a20(gate_a20), .host_a20_cmd(host_a20_cmd), .host_a20_val(host_a20_val),
  .a20_fw_lo(a20_fw_lo), .a20_fw_hi(a20_fw_hi)
);

// File: tb/kbc_obf_irq_test.sv
`timescale 1ns/1ps
module kbc_obf_irq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fw_we = 1'b0;
  logic [15:0] fw_addr = 16'h0000;
  logic [7:0]  fw_wdata = 8'h00;
  logic [7:0]  fw_rdata;
  logic        host_rd_data = 1'b0;
  logic        host_a20_cmd = 1'b0;
  logic        host_a20_val = 1'b0;
  logic [7:0]  host_odata;
  logic        pc_obf, aux_obf, kirq, mirq, gate_a20;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  logic [7:0] m_cfg = 8'h00;
  logic [7:0] m_od = 8'h00;
  logic       m_hw = 1'b0, m_lat = 1'b0, m_aux = 1'b0, m_a20 = 1'b0;

  always #5 clk = ~clk;

  kbc_obf_irq uut (
    .clk(clk), .rst_n(rst_n), .fw_we(fw_we), .fw_addr(fw_addr), .fw_wdata(fw_wdata),
    .fw_rdata(fw_rdata), .host_rd_data(host_rd_data), .host_a20_cmd(host_a20_cmd),
    .host_a20_val(host_a20_val), .host_odata(host_odata), .pc_obf(pc_obf),
    .aux_obf(aux_obf), .kirq(kirq), .mirq(mirq), .gate_a20(gate_a20)
  );

  function automatic logic exp_pc();
    return m_cfg[2] ? m_lat : m_hw;
  endfunction

  function automatic logic [7:0] exp_stat();
    return {2'b00, m_aux, 4'b0000, exp_pc()};
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_fw(input logic [15:0] a, input logic [7:0] d);
    case (a)
      16'h7FF4: m_cfg = d & 8'hAF;
      16'h7FF1: begin m_od = d; m_hw = 1'b1; end
      16'h7FFA: begin m_od = d; if (m_cfg[7]) m_aux = 1'b1; end
      16'h7FF2: if (!m_cfg[7]) m_aux = d[5];
      16'h7FFD: m_lat = d[0];
      16'h7FFE: m_a20 = 1'b0;
      16'h7FFF: m_a20 = 1'b1;
      default: ;
    endcase
  endtask

  task automatic fw_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    fw_we = 1'b1; fw_addr = a; fw_wdata = d;
    @(negedge clk);
    fw_we = 1'b0;
    model_fw(a, d);
  endtask

  task automatic host_read();
    @(negedge clk);
    host_rd_data = 1'b1;
    @(negedge clk);
    host_rd_data = 1'b0;
    m_hw = 1'b0;
    if (m_cfg[7]) m_aux = 1'b0;
  endtask

  task automatic host_a20(input logic v);
    @(negedge clk);
    host_a20_cmd = 1'b1; host_a20_val = v;
    @(negedge clk);
    host_a20_cmd = 1'b0;
    if (!m_cfg[1]) m_a20 = v;
  endtask

  task automatic fw_read(input string req, input logic [15:0] a, input logic [7:0] exp);
    fw_addr = a;
    #1;
    chk(req, "fw_rdata", fw_rdata, exp);
  endtask

  // waits one extra cycle so the registered interrupts have settled
  task automatic check_all();
    @(negedge clk);
    chk("R3", "pc_obf", {7'b0, pc_obf}, {7'b0, exp_pc()});
    chk("R5", "aux_obf", {7'b0, aux_obf}, {7'b0, m_aux});
    chk("R8", "kirq", {7'b0, kirq}, {7'b0, m_cfg[5] & exp_pc()});
    chk("R8", "mirq", {7'b0, mirq}, {7'b0, m_cfg[5] & m_aux});
    chk("R9", "gate_a20", {7'b0, gate_a20}, {7'b0, m_a20});
    chk("R11", "host_odata", host_odata, m_od);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    fw_read("R1", 16'h7FF4, 8'h00);
    chk("R1", "outs", {3'b0, pc_obf, aux_obf, kirq, mirq, gate_a20}, 8'h00);
    chk("R1", "host_odata", host_odata, 8'h00);

    // R2 readback mask, stored-only bits
    fw_write(16'h7FF4, 8'hFF);
    fw_read("R2", 16'h7FF4, 8'hAF);
    fw_write(16'h7FF4, 8'h09);
    fw_read("R2", 16'h7FF4, 8'h09);
    check_all();
    chk("R2", "no effect", {3'b0, pc_obf, aux_obf, kirq, mirq, gate_a20}, 8'h00);

    // R3, R8 lag, R11
    fw_write(16'h7FF4, 8'h20);
    fw_write(16'h7FF1, 8'h5A);
    chk("R3", "pc_obf set", {7'b0, pc_obf}, 8'h01);
    chk("R8", "kirq lag", {7'b0, kirq}, 8'h00);
    @(negedge clk);
    chk("R8", "kirq after lag", {7'b0, kirq}, 8'h01);
    chk("R11", "host_odata", host_odata, 8'h5A);
    fw_read("R7", 16'h7FF2, 8'h01);
    host_read();
    chk("R3", "pc_obf clr", {7'b0, pc_obf}, 8'h00);
    check_all();

    // R4 firmware latch
    fw_write(16'h7FF4, 8'h24);
    fw_write(16'h7FFD, 8'h01);
    check_all();
    chk("R4", "latch set", {7'b0, pc_obf}, 8'h01);
    host_read();
    check_all();
    chk("R4", "host read ignored", {7'b0, pc_obf}, 8'h01);
    fw_write(16'h7FFD, 8'hFE);
    check_all();
    chk("R4", "latch clr", {7'b0, pc_obf}, 8'h00);

    // R5 aux hardware
    fw_write(16'h7FF4, 8'hA0);
    fw_write(16'h7FFA, 8'hC3);
    check_all();
    chk("R5", "aux set", {7'b0, aux_obf}, 8'h01);
    chk("R8", "mirq", {7'b0, mirq}, 8'h01);
    fw_read("R7", 16'h7FF2, 8'h20);
    host_read();
    check_all();
    chk("R5", "aux clr", {7'b0, aux_obf}, 8'h00);

    // R6 aux user bit
    fw_write(16'h7FF4, 8'h20);
    fw_write(16'h7FF2, 8'h20);
    check_all();
    chk("R6", "aux from status", {7'b0, aux_obf}, 8'h01);
    fw_write(16'h7FFA, 8'h11);
    host_read();
    check_all();
    chk("R6", "aux held", {7'b0, aux_obf}, 8'h01);
    fw_write(16'h7FF4, 8'h00);
    check_all();
    chk("R8", "gated off", {6'b0, kirq, mirq}, 8'h00);
    fw_write(16'h7FF2, 8'hDF);
    check_all();
    chk("R6", "aux cleared", {7'b0, aux_obf}, 8'h00);

    // R9 last-wins, data ignored
    fw_write(16'h7FFF, 8'h00);
    check_all();
    host_a20(1'b0);
    check_all();
    chk("R9", "host low", {7'b0, gate_a20}, 8'h00);
    host_a20(1'b1);
    fw_write(16'h7FFE, 8'hFF);
    check_all();
    chk("R9", "fw low", {7'b0, gate_a20}, 8'h00);
    // R9 same-cycle collision: firmware wins
    @(negedge clk);
    fw_we = 1'b1; fw_addr = 16'h7FFE; fw_wdata = 8'h00;
    host_a20_cmd = 1'b1; host_a20_val = 1'b1;
    @(negedge clk);
    fw_we = 1'b0; host_a20_cmd = 1'b0;
    chk("R9", "collision", {7'b0, gate_a20}, 8'h00);

    // R10 firmware-only gate
    fw_write(16'h7FF4, 8'h02);
    host_a20(1'b1);
    check_all();
    chk("R10", "host ignored", {7'b0, gate_a20}, 8'h00);
    fw_write(16'h7FFF, 8'h00);
    host_a20(1'b0);
    check_all();
    chk("R10", "fw high kept", {7'b0, gate_a20}, 8'h01);

    // constrained random mix over all configuration pairings
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [7:0] d;
      op = int'($urandom_range(0, 8));
      d  = 8'($urandom);
      case (op)
        0: begin
          if (exp_pc()) d[5] = m_cfg[5];
          fw_write(16'h7FF4, d);
        end
        1: fw_write(16'h7FF1, d);
        2: fw_write(16'h7FFA, d);
        3: fw_write(16'h7FF2, d);
        4: fw_write(16'h7FFD, d);
        5: fw_write(d[0] ? 16'h7FFF : 16'h7FFE, d);
        6: host_a20(d[1]);
        default: host_read();
      endcase
      check_all();
      fw_read("R7", 16'h7FF2, exp_stat());
      fw_read("R2", 16'h7FF4, m_cfg);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule